// File: doc/BRIEF.md
# Periodic Battery-Low Monitor

This block decides when the backup battery of a memory-retention circuit gets tested, and it holds the result. Tests happen only while the main supply is valid. One test runs each time the supply becomes valid. After that, further tests run each time a long interval, counted in timebase ticks, has elapsed. During a test the block raises a request that enables an external analog comparator. It waits for the comparator to settle, then samples the comparator's digital "battery below threshold" flag on the last cycle of the request.

The result sits in a latched flag and drives an active-low open-drain indicator. The indicator is modelled as a drive-low enable: 1 pulls the line low and means "battery low". The flag changes only at the end of a completed test. It therefore survives supply loss, and it is re-evaluated by the test that follows the next power-up. A supply loss in the middle of a test cancels that test and leaves the flag as it was.

Top module: `batt_low_monitor`

## Requirements
- R1: After reset, `bl_drive_low` and `cmp_req` are both 0.
- R2: When `supply_ok` is first sampled high (after reset or after being sampled low), `cmp_req` rises in the next cycle and stays high for exactly SETTLE_CYCLES cycles, unless the supply drops first.
- R3: Only the value of `batt_below` in the last cycle of the request is used; its values in earlier request cycles have no effect on the result.
- R4: A completed test that samples `batt_below`=1 sets `bl_drive_low` to 1 from the cycle after the last request cycle; a sample of 0 sets it to 0 in that same cycle.
- R5: `bl_drive_low` keeps its value between tests; `batt_below` has no effect while `cmp_req` is low.
- R6: With the supply valid, ticks are counted from zero, starting after each power-up or periodic test start. The cycle in which the INTERVAL_TICKS-th tick arrives starts a periodic test, so `cmp_req` is high in the following cycle and not before.
- R7: While `supply_ok` is low, `cmp_req` stays 0 and `tick` is ignored.
- R8: If `supply_ok` drops during a request, including in its last cycle, `cmp_req` falls in that cycle, nothing is sampled, and `bl_drive_low` is unchanged.
- R9: `bl_drive_low` holds its value while the supply is off and through the following power-up test, until that test completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_ok | input | 1 | Main supply within tolerance |
| tick | input | 1 | One-cycle timebase pulse for the interval counter |
| batt_below | input | 1 | Comparator result, 1 = battery under threshold |
| cmp_req | output | 1 | Enables the external comparator during a test |
| bl_drive_low | output | 1 | Open-drain pull-down enable, 1 = battery low indicated |

## Verification
The two events that can share a cycle are supply loss and the sampling cycle at the end of a test. Shared cycles are the point where an abort and a completion compete. The bench provokes this overlap by dropping `supply_ok` in exactly the last request cycle while the comparator reports a low battery. It then judges the outcome from the request pulse, which is one cycle short, and from the indicator, which keeps its earlier value. A second abort part-way through a periodic test, together with a completed test after each abort, shows that the cancelled test left no trace.

// File: rtl/bl_pkg.sv
package bl_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  // Counter width able to hold values 0 .. n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bl_rst_sync.sv
module bl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bl_interval_timer.sv
module bl_interval_timer
  import bl_pkg::*;
#(
  parameter int unsigned INTERVAL_TICKS = 86400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic restart,
  input  logic tick,
  output logic expire
);

  localparam int unsigned CW = cnt_width(INTERVAL_TICKS);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (!supply_ok || restart) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (tick) begin
      cnt_en = 1'b1;
      if (at_last) begin
        cnt_d  = '0;
        expire = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bl_check_seq.sv
module bl_check_seq
  import bl_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic start,
  output logic busy,
  output logic cmp_req,
  output logic sample_now
);

  localparam int unsigned SW = cnt_width(SETTLE_CYCLES);
  localparam logic [SW-1:0] LAST = SW'(SETTLE_CYCLES - 1);

  seq_state_e    state_q, state_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic          scnt_en;

  always_comb begin
    state_d    = state_q;
    scnt_d     = scnt_q;
    scnt_en    = 1'b0;
    sample_now = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_BUSY;
          scnt_d  = '0;
          scnt_en = 1'b1;
        end
      end
      SEQ_BUSY: begin
        if (!supply_ok) begin
          state_d = SEQ_IDLE;
        end else if (scnt_q == LAST) begin
          state_d    = SEQ_IDLE;
          sample_now = 1'b1;
        end else begin
          scnt_d  = scnt_q + 1'b1;
          scnt_en = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      scnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (scnt_en) scnt_q <= scnt_d;
    end
  end

  assign busy    = (state_q == SEQ_BUSY);
  assign cmp_req = busy & supply_ok;

endmodule

// File: rtl/bl_flag_latch.sv
module bl_flag_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic value,
  output logic flag
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (load) flag_d = value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (load) flag_q <= flag_d;
  end

  assign flag = flag_q;

endmodule

// File: rtl/batt_low_monitor.sv
module batt_low_monitor #(
  parameter int unsigned INTERVAL_TICKS = 86400,
  parameter int unsigned SETTLE_CYCLES  = 8,
  parameter int unsigned RST_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic tick,
  input  logic batt_below,
  output logic cmp_req,
  output logic bl_drive_low
);

  logic rst_sync_n;
  logic sup_q;
  logic pwr_up;
  logic expire;
  logic busy;
  logic seq_start;
  logic sample_now;

  bl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Previous supply state: a low-to-high step marks a power-up
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sup_q <= 1'b0;
    else             sup_q <= supply_ok;
  end

  assign pwr_up    = supply_ok & ~sup_q;
  assign seq_start = pwr_up | (expire & ~busy);

  bl_interval_timer #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .supply_ok (supply_ok),
    .restart   (pwr_up),
    .tick      (tick),
    .expire    (expire)
  );

  bl_check_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .supply_ok  (supply_ok),
    .start      (seq_start),
    .busy       (busy),
    .cmp_req    (cmp_req),
    .sample_now (sample_now)
  );

  bl_flag_latch u_flag (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (sample_now),
    .value (batt_below),
    .flag  (bl_drive_low)
  );

endmodule

// File: rtl/bl_monitor_chk.sv
module bl_monitor_chk #(
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic cmp_req,
  input logic bl_drive_low,
  input logic pwr_up,
  input logic seq_start
);

  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (cmp_req) run_q <= run_q + 1;
    else              run_q <= '0;
  end

  // R2
  powerup_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> (cmp_req || !supply_ok));

  // R2
  req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |-> (run_q < SETTLE_CYCLES));

  // R6
  start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> (cmp_req || !supply_ok));

  // R5
  flag_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_drive_low != $past(bl_drive_low)) |-> $past(cmp_req));

  // R9
  flag_hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> $stable(bl_drive_low));

endmodule

bind batt_low_monitor bl_monitor_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .supply_ok    (supply_ok),
  .cmp_req      (cmp_req),
  .bl_drive_low (bl_drive_low),
  .pwr_up       (pwr_up),
  .seq_start    (seq_start)
);

// File: tb/batt_low_monitor_tb.sv
module batt_low_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_TICKS    = 5;
  localparam int SETTLE     = 4;

  logic clk = 1'b0;
  logic rst_n, supply_ok, tick, batt_below;
  logic cmp_req, bl_drive_low;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    int    len;
    logic  bl;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  batt_low_monitor #(
    .INTERVAL_TICKS(N_TICKS),
    .SETTLE_CYCLES (SETTLE)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .tick         (tick),
    .batt_below   (batt_below),
    .cmp_req      (cmp_req),
    .bl_drive_low (bl_drive_low)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Inputs change 2 time units after a rising edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic push(input int len, input logic bl, input string tag);
    exp_t e;
    e.len = len;
    e.bl  = bl;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: measures each request pulse and the indicator right after it
  initial begin : monitor
    int len;
    exp_t e;
    len = 0;
    forever begin
      @(negedge clk);
      if (cmp_req === 1'b1) begin
        len++;
      end else if (len > 0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected request", len, 0);
        end else begin
          e = exp_q.pop_front();
          check(len == e.len, {e.tag, " request length"}, len, e.len);
          check(bl_drive_low === e.bl, {e.tag, " indicator after test"},
                int'(bl_drive_low), int'(e.bl));
        end
        len = 0;
      end
    end
  end

  // Called in the slot after the trigger was driven
  task automatic run_test(input logic fin, input logic early, input int abort_at,
                          input string tag);
    for (int k = 1; k <= SETTLE; k++) begin
      step();
      tick = 1'b0;
      if (k == 1 && abort_at != 1)
        check(cmp_req === 1'b1, {tag, " request starts"}, int'(cmp_req), 1);
      batt_below = (k == SETTLE) ? fin : early;
      if (k == abort_at) supply_ok = 1'b0;
    end
    step();
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
      check(cmp_req === 1'b0, "R6 no early request", int'(cmp_req), 0);
      step();
    end
  endtask

  // Final tick of an interval, then a periodic test
  task automatic periodic(input logic fin, input logic early, input logic exp_bl,
                          input int abort_at, input string tag);
    give_ticks(N_TICKS - 1);
    push((abort_at == 0) ? SETTLE : abort_at - 1, exp_bl, tag);
    tick = 1'b1;
    check(cmp_req === 1'b0, "R6 not before last tick", int'(cmp_req), 0);
    run_test(fin, early, abort_at, tag);
  endtask

  initial begin : driver
    rst_n = 1'b0; supply_ok = 1'b0; tick = 1'b0; batt_below = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R1
    check(bl_drive_low === 1'b0, "R1 indicator after reset", int'(bl_drive_low), 0);
    check(cmp_req === 1'b0, "R1 request after reset", int'(cmp_req), 0);

    // R7: ticks with no supply
    for (int i = 0; i < 12; i++) begin
      tick = 1'b1;
      batt_below = 1'b1;
      step();
      check(cmp_req === 1'b0, "R7 no request while supply off", int'(cmp_req), 0);
    end
    tick = 1'b0;

    // R2 R4: power-up test, battery low
    push(SETTLE, 1'b1, "R4 powerup low");
    supply_ok = 1'b1;
    run_test(1'b1, 1'b1, 0, "R2");
    step();

    // R5: comparator ignored between tests
    batt_below = 1'b0;
    repeat (8) begin
      step();
      check(bl_drive_low === 1'b1, "R5 latched low kept", int'(bl_drive_low), 1);
    end

    // R6: periodic test clears the flag (battery good)
    periodic(1'b0, 1'b0, 1'b0, 0, "R6 periodic good");
    step();

    // R3: only last request cycle matters
    periodic(1'b1, 1'b0, 1'b1, 0, "R3 last cycle high");
    step();
    periodic(1'b0, 1'b1, 1'b0, 0, "R3 last cycle low");
    step();

    // R9: set low, drop supply, hold, power-up re-evaluates
    periodic(1'b1, 1'b1, 1'b1, 0, "R9 set low");
    step();
    supply_ok = 1'b0;
    batt_below = 1'b0;
    repeat (6) begin
      step();
      check(bl_drive_low === 1'b1, "R9 held while off", int'(bl_drive_low), 1);
    end
    push(SETTLE, 1'b0, "R9 powerup good");
    supply_ok = 1'b1;
    step();
    check(bl_drive_low === 1'b1, "R9 held during powerup test", int'(bl_drive_low), 1);
    for (int k = 2; k <= SETTLE; k++) begin
      batt_below = 1'b0;
      step();
    end
    step();
    step();

    // R8: supply lost in the final request cycle while battery reads low
    supply_ok = 1'b0;
    repeat (3) step();
    push(SETTLE - 1, 1'b0, "R8 abort on last cycle");
    supply_ok = 1'b1;
    run_test(1'b1, 1'b1, SETTLE, "R8");
    repeat (3) begin
      step();
      check(bl_drive_low === 1'b0, "R8 indicator unchanged", int'(bl_drive_low), 0);
    end

    // Power back: completed test still works, then abort a periodic one early
    push(SETTLE, 1'b1, "R8 powerup after abort");
    supply_ok = 1'b1;
    run_test(1'b1, 1'b1, 0, "R2");
    step();
    periodic(1'b0, 1'b0, 1'b1, 2, "R8 abort mid test");
    repeat (3) begin
      step();
      check(bl_drive_low === 1'b1, "R8 kept after mid abort", int'(bl_drive_low), 1);
      check(cmp_req === 1'b0, "R7 no request after abort", int'(cmp_req), 0);
    end

    repeat (4) step();
    check(exp_q.size() == 0, "R2 all expected tests seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule